// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the purely combinational arithmetic and logic stage of a 32-bit integer datapath. An instruction decoder hands it a 4-bit opcode, a first operand, a second operand that a barrel shifter has already shifted, the current condition flags and the shifter's carry-out. It also receives a bit asking for a flag update and a bit saying that the destination is the program counter. In the same cycle it returns the operation result, a write-enable for the destination register and the next value of the N, Z, C and V flags.

Every add and subtract form goes through one shared adder. Subtraction is done as an addition of the inverted operand. Reverse forms swap the operands before the adder. The carry-chained forms feed the current C flag in as the adder's carry-in.

A flag update is committed only when the set-flags bit is high and the destination is not the program counter. Test and compare operations produce flags but never write a register.

Top module: `dp_alu`

## Requirements
- R1: Opcode 0000 returns A AND B, 0001 returns A XOR B, 1100 returns A OR B, and 1110 returns A AND NOT B.
- R2: Opcode 1101 returns B and opcode 1111 returns NOT B. For both, operand A has no effect on any output.
- R3: Opcode 0100 returns A+B and opcode 0101 returns A+B+C. When flags are written, C is the carry out of bit 31 and V flags signed overflow into bit 31.
- R4: Opcode 0010 returns A+NOT B+1 and opcode 0011 returns B+NOT A+1. C is the adder carry-out, so C=1 means no borrow. V flags signed overflow.
- R5: Opcode 0110 returns A+NOT B+C and opcode 0111 returns B+NOT A+C, where C is the incoming carry flag.
- R6: When flags are written, Z is 1 exactly when the 32-bit result is zero, and N equals result bit 31.
- R7: Opcodes 1000 (AND test), 1001 (XOR test), 1010 (compare, as 0010) and 1011 (compare-negative, as 0100) update flags like their counterparts and hold the destination write-enable low. All other opcodes drive it high.
- R8: When set_flags is 0 or dest_is_pc is 1, flags_we is 0 and flags_out equals flags_in. Otherwise flags_we is 1.
- R9: For logical opcodes (0000, 0001, 1000, 1001, 1100, 1101, 1110, 1111), a flag write takes C from shift_carry and keeps V from flags_in.
- R10: The flag vectors are ordered {N,Z,C,V}, with bit 1 being C. The C bit of flags_in is the carry-in used by 0101, 0110 and 0111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Shifted second operand |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| shift_carry | input | 1 | Carry-out of the barrel shifter |
| set_flags | input | 1 | Request a flag update |
| dest_is_pc | input | 1 | Destination register is the program counter |
| result | output | 32 | Operation result |
| rd_we | output | 1 | Destination write-enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| flags_we | output | 1 | Flags were updated |

## Verification
The bench targets the overflow boundaries at both ends of the signed range. A design that computed V from the result alone, or from the raw B operand instead of the inverted adder input, would report the wrong overflow on 0x7FFFFFFF+1 and on 0x80000000-1.

It checks that C means "no borrow" on equal and on smaller minuends. It also runs the chained subtracts with carry clear, where a design that always added one would be off by one.

The remaining cases are a flag request with the program counter as destination, compare operations that must not write a register, and logical operations that must keep V and take C from the shifter. A design that got these wrong would corrupt flags or register contents on those cases.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'b0000,
      OP_EOR = 4'b0001,
      OP_SUB = 4'b0010,
      OP_RSB = 4'b0011,
      OP_ADD = 4'b0100,
      OP_ADC = 4'b0101,
      OP_SBC = 4'b0110,
      OP_RSC = 4'b0111,
      OP_TST = 4'b1000,
      OP_TEQ = 4'b1001,
      OP_CMP = 4'b1010,
      OP_CMN = 4'b1011,
      OP_ORR = 4'b1100,
      OP_MOV = 4'b1101,
      OP_BIC = 4'b1110,
      OP_MVN = 4'b1111
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } alu_flags_t;

   function automatic logic op_is_arith(input alu_op_e op);
      case (op)
         OP_SUB, OP_RSB, OP_ADD, OP_ADC,
         OP_SBC, OP_RSC, OP_CMP, OP_CMN: return 1'b1;
         default:                         return 1'b0;
      endcase
   endfunction

   function automatic logic op_is_test(input alu_op_e op);
      return (op[3:2] == 2'b10);
   endfunction

endpackage

// File: rtl/dp_logic_unit.sv
module dp_logic_unit
   import dp_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);

   always_comb begin
      case (op)
         OP_AND, OP_TST: y = a & b;
         OP_EOR, OP_TEQ: y = a ^ b;
         OP_ORR:         y = a | b;
         OP_MOV:         y = b;
         OP_BIC:         y = a & ~b;
         OP_MVN:         y = ~b;
         default:        y = '0;
      endcase
   end

   // R2: the move forms must not depend on A
   always_comb begin
      if (op == OP_MOV) begin
         p_mov_passes_b_r2: assert (y == b);
      end
      if (op == OP_MVN) begin
         p_mvn_inverts_b_r2: assert (y == ~b);
      end
   end

endmodule

// File: rtl/dp_adder.sv
module dp_adder
   import dp_alu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit ADDER_RIPPLE = 1'b0
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin_flag,
   output logic [DATA_W-1:0] sum,
   output logic              cout,
   output logic              ovf
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] x;
   logic [DATA_W-1:0] y;
   logic              cin;

   // operand steering: reverse forms swap, subtract forms invert
   always_comb begin
      x   = a;
      y   = b;
      cin = 1'b0;
      case (op)
         OP_SUB, OP_CMP: begin x = a; y = ~b; cin = 1'b1;     end
         OP_RSB:         begin x = b; y = ~a; cin = 1'b1;     end
         OP_ADD, OP_CMN: begin x = a; y = b;  cin = 1'b0;     end
         OP_ADC:         begin x = a; y = b;  cin = cin_flag; end
         OP_SBC:         begin x = a; y = ~b; cin = cin_flag; end
         OP_RSC:         begin x = b; y = ~a; cin = cin_flag; end
         default:        begin x = a; y = b;  cin = 1'b0;     end
      endcase
   end

   generate
      if (ADDER_RIPPLE) begin : g_ripple
         always_comb begin
            logic c;
            c = cin;
            for (int i = 0; i < DATA_W; i++) begin
               sum[i] = x[i] ^ y[i] ^ c;
               c      = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
            end
            cout = c;
         end
      end else begin : g_behav
         logic [DATA_W:0] wide;
         always_comb begin
            wide = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
            sum  = wide[DATA_W-1:0];
            cout = wide[DATA_W];
         end
      end
   endgenerate

   assign ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);

   // R3: two non-negative addends can never report a carry-out
   always_comb begin
      if ((op == OP_ADD) && !a[MSB] && !b[MSB]) begin
         p_no_carry_small_r3: assert (!cout);
      end
   end

endmodule

// File: rtl/dp_flag_unit.sv
module dp_flag_unit
   import dp_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] res,
   input  logic              is_arith,
   input  logic              add_cout,
   input  logic              add_ovf,
   input  logic              shift_carry,
   input  alu_flags_t        cur,
   input  logic              set_flags,
   input  logic              dest_is_pc,
   output alu_flags_t        nxt,
   output logic              upd
);

   alu_flags_t computed;

   always_comb begin
      computed.n = res[DATA_W-1];
      computed.z = (res == '0);
      computed.c = is_arith ? add_cout : shift_carry;
      computed.v = is_arith ? add_ovf  : cur.v;
   end

   assign upd = set_flags && !dest_is_pc;
   assign nxt = upd ? computed : cur;

endmodule

// File: rtl/dp_alu.sv
module dp_alu
   import dp_alu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit ADDER_RIPPLE = 1'b0
) (
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [3:0]        flags_in,
   input  logic              shift_carry,
   input  logic              set_flags,
   input  logic              dest_is_pc,
   output logic [DATA_W-1:0] result,
   output logic              rd_we,
   output logic [3:0]        flags_out,
   output logic              flags_we
);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("dp_alu: DATA_W must be at least 8");
      end
   endgenerate

   alu_op_e           op_e;
   logic [DATA_W-1:0] logic_y;
   logic [DATA_W-1:0] add_sum;
   logic              add_cout;
   logic              add_ovf;
   logic              arith;
   alu_flags_t        cur_f;
   alu_flags_t        nxt_f;

   assign op_e  = alu_op_e'(op);
   assign arith = op_is_arith(op_e);
   assign cur_f = alu_flags_t'(flags_in);

   dp_logic_unit #(.DATA_W(DATA_W)) u_logic (
      .op (op_e),
      .a  (opnd_a),
      .b  (opnd_b),
      .y  (logic_y)
   );

   dp_adder #(.DATA_W(DATA_W), .ADDER_RIPPLE(ADDER_RIPPLE)) u_adder (
      .op       (op_e),
      .a        (opnd_a),
      .b        (opnd_b),
      .cin_flag (cur_f.c),
      .sum      (add_sum),
      .cout     (add_cout),
      .ovf      (add_ovf)
   );

   assign result = arith ? add_sum : logic_y;
   assign rd_we  = !op_is_test(op_e);

   dp_flag_unit #(.DATA_W(DATA_W)) u_flags (
      .res         (result),
      .is_arith    (arith),
      .add_cout    (add_cout),
      .add_ovf     (add_ovf),
      .shift_carry (shift_carry),
      .cur         (cur_f),
      .set_flags   (set_flags),
      .dest_is_pc  (dest_is_pc),
      .nxt         (nxt_f),
      .upd         (flags_we)
   );

   assign flags_out = nxt_f;

   always_comb begin
      if (!set_flags || dest_is_pc) begin
         p_hold_flags_r8: assert (flags_out == flags_in && !flags_we);
      end
      if (flags_we) begin
         p_zero_flag_r6: assert (flags_out[2] == (result == '0));
         p_neg_flag_r6:  assert (flags_out[3] == result[DATA_W-1]);
      end
      if (flags_we && !arith) begin
         p_logic_flags_r9: assert (flags_out[0] == flags_in[0] && flags_out[1] == shift_carry);
      end
      if (op[3:2] == 2'b10) begin
         p_test_no_write_r7: assert (!rd_we);
      end
   end

endmodule

// File: tb/test_dp_alu.sv
module test_dp_alu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op;
   logic [31:0] opnd_a, opnd_b, result;
   logic [3:0]  flags_in, flags_out;
   logic        shift_carry, set_flags, dest_is_pc, rd_we, flags_we;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   dp_alu i_dp_alu (
      .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in),
      .shift_carry(shift_carry), .set_flags(set_flags), .dest_is_pc(dest_is_pc),
      .result(result), .rd_we(rd_we), .flags_out(flags_out), .flags_we(flags_we)
   );

   typedef struct packed {
      logic [3:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      logic [3:0]  fin;
      logic        sc;
      logic [31:0] res;
      logic [3:0]  fl;
      logic        we;
   } vec_t;

   localparam int NV = 19;
   // flags {N,Z,C,V}; set_flags=1, dest_is_pc=0 for every row
   localparam vec_t TABLE [NV] = '{
      '{4'h0, 32'hF0F0F0F0, 32'h0FF00FF0, 4'b0000, 1'b1, 32'h00F000F0, 4'b0010, 1'b1}, // R1 R9
      '{4'h1, 32'hFFFF0000, 32'h0F0F0F0F, 4'b0001, 1'b0, 32'hF0F00F0F, 4'b1001, 1'b1}, // R1 R9
      '{4'hC, 32'h00000000, 32'h00000000, 4'b1111, 1'b0, 32'h00000000, 4'b0101, 1'b1}, // R1 R6
      '{4'hE, 32'hFFFFFFFF, 32'h0000FFFF, 4'b0000, 1'b1, 32'hFFFF0000, 4'b1010, 1'b1}, // R1
      '{4'hD, 32'h12345678, 32'h80000000, 4'b0000, 1'b0, 32'h80000000, 4'b1000, 1'b1}, // R2
      '{4'hF, 32'hDEADBEEF, 32'hFFFFFFFF, 4'b0001, 1'b1, 32'h00000000, 4'b0111, 1'b1}, // R2 R9
      '{4'h4, 32'h7FFFFFFF, 32'h00000001, 4'b0000, 1'b0, 32'h80000000, 4'b1001, 1'b1}, // R3
      '{4'h4, 32'hFFFFFFFF, 32'h00000001, 4'b0000, 1'b0, 32'h00000000, 4'b0110, 1'b1}, // R3
      '{4'h5, 32'h00000001, 32'h00000002, 4'b0010, 1'b0, 32'h00000004, 4'b0000, 1'b1}, // R3 R10
      '{4'h2, 32'h00000005, 32'h00000005, 4'b0000, 1'b0, 32'h00000000, 4'b0110, 1'b1}, // R4
      '{4'h2, 32'h00000003, 32'h00000005, 4'b0000, 1'b0, 32'hFFFFFFFE, 4'b1000, 1'b1}, // R4
      '{4'h2, 32'h80000000, 32'h00000001, 4'b0000, 1'b0, 32'h7FFFFFFF, 4'b0011, 1'b1}, // R4
      '{4'h3, 32'h00000001, 32'h0000000A, 4'b0000, 1'b0, 32'h00000009, 4'b0010, 1'b1}, // R4
      '{4'h6, 32'h0000000A, 32'h00000003, 4'b0000, 1'b0, 32'h00000006, 4'b0010, 1'b1}, // R5
      '{4'h7, 32'h00000003, 32'h00000003, 4'b0000, 1'b0, 32'hFFFFFFFF, 4'b1000, 1'b1}, // R5
      '{4'h8, 32'h000000F0, 32'h0000000F, 4'b0000, 1'b1, 32'h00000000, 4'b0110, 1'b0}, // R7
      '{4'h9, 32'hAAAAAAAA, 32'hAAAAAAAA, 4'b0001, 1'b0, 32'h00000000, 4'b0101, 1'b0}, // R7
      '{4'hA, 32'h00000002, 32'h00000003, 4'b0000, 1'b0, 32'hFFFFFFFF, 4'b1000, 1'b0}, // R7
      '{4'hB, 32'h80000000, 32'h80000000, 4'b0000, 1'b0, 32'h00000000, 4'b0111, 1'b0}  // R7
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [3:0] f, input logic sc, input logic sf, input logic pc);
      @(posedge clk);
      op = o; opnd_a = a; opnd_b = b; flags_in = f;
      shift_carry = sc; set_flags = sf; dest_is_pc = pc;
      @(negedge clk);
   endtask

   initial begin
      op = 4'h0; opnd_a = '0; opnd_b = '0; flags_in = 4'b0000;
      shift_carry = 1'b0; set_flags = 1'b0; dest_is_pc = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // idle state: AND of zeros, no flag request (R8 R1)
      check("R8 idle flags_we", {63'd0, flags_we}, 64'd0);
      check("R1 idle result",   {32'd0, result},   64'd0);

      for (int i = 0; i < NV; i++) begin
         apply(TABLE[i].op, TABLE[i].a, TABLE[i].b, TABLE[i].fin, TABLE[i].sc, 1'b1, 1'b0);
         check($sformatf("R6 vec%0d result", i), {32'd0, result}, {32'd0, TABLE[i].res});
         check($sformatf("R3 vec%0d flags", i), {60'd0, flags_out}, {60'd0, TABLE[i].fl});
         check($sformatf("R7 vec%0d rd_we", i), {63'd0, rd_we}, {63'd0, TABLE[i].we});
         check($sformatf("R8 vec%0d flags_we", i), {63'd0, flags_we}, 64'd1);
      end

      // R8: overflowing add without set_flags keeps flags
      apply(4'h4, 32'h7FFFFFFF, 32'h1, 4'b0110, 1'b0, 1'b0, 1'b0);
      check("R8 no set flags_out", {60'd0, flags_out}, 64'h6);
      check("R8 no set flags_we",  {63'd0, flags_we},  64'd0);
      check("R3 no set result",    {32'd0, result},    64'h80000000);
      // R8: destination is program counter
      apply(4'h2, 32'h5, 32'h5, 4'b1001, 1'b1, 1'b1, 1'b1);
      check("R8 pc flags_out", {60'd0, flags_out}, 64'h9);
      check("R8 pc flags_we",  {63'd0, flags_we},  64'd0);
      check("R7 pc rd_we",     {63'd0, rd_we},     64'd1);
      // R7: compare without set_flags writes nothing
      apply(4'hA, 32'h1, 32'h2, 4'b0000, 1'b0, 1'b0, 1'b0);
      check("R7 cmp nowrite rd_we", {63'd0, rd_we},     64'd0);
      check("R7 cmp nowrite flags", {60'd0, flags_out}, 64'h0);
      // R2: MOV ignores A
      apply(4'hD, 32'hFFFFFFFF, 32'h00000055, 4'b0000, 1'b0, 1'b1, 1'b0);
      check("R2 mov ignores A", {32'd0, result}, 64'h55);
      // R5 R10: SBC and RSC with carry set behave as plain subtract
      apply(4'h6, 32'hA, 32'h3, 4'b0010, 1'b0, 1'b1, 1'b0);
      check("R5 sbc carry set", {32'd0, result}, 64'h7);
      apply(4'h7, 32'h3, 32'hA, 4'b0010, 1'b0, 1'b1, 1'b0);
      check("R5 rsc carry set", {32'd0, result}, 64'h7);
      // R9: logical op, V kept set, shifter carry cleared
      apply(4'h0, 32'h1, 32'h1, 4'b0011, 1'b0, 1'b1, 1'b0);
      check("R9 and V keep C shifter", {60'd0, flags_out}, 64'h1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule